// File: doc/BRIEF.md
# Dual-Channel Phase-Offset Switching Clock

This block derives the switching-cycle timing for a pair of synchronous buck channels from one fast system clock. Each channel gets a one-cycle start strobe at the beginning of every switching period. The period is the system clock rate divided by the target switching rate, in whole cycles. Channel 2's period is offset from channel 1's by half a period, a quarter period, or nothing. The choice comes from two sampled configuration levels. One selects memory-tracking operation. The other says the power input is a regulated 5 V rail rather than a battery.

The block also drives a forced-PWM flag for each channel, which keeps the downstream control out of light-load hysteretic operation. A channel is forced while its soft-start has not finished. Channel 2 is forced permanently while tracking operation is latched. The configuration levels are captured only while both channels are disabled, so the phase relationship cannot move while the converters are switching. A synchronous reset, or any cycle with both channels disabled, realigns the two period counters so that the first strobes already carry the chosen offset.

Top module: `pwm_phase_clkgen`

## Requirements
- R1: Every enabled channel strobes once every PERIOD = CLK_HZ / SW_HZ system cycles (integer division; 166 at the defaults of 50 MHz and 300 kHz).
- R2: With `track_mode` latched low, channel 2's strobe comes PERIOD/2 cycles (83 at defaults) after channel 1's, whatever `rail_5v` is.
- R3: With `track_mode` latched high and `rail_5v` latched high, channel 2's strobe comes PERIOD/4 cycles (41 at defaults) after channel 1's.
- R4: With `track_mode` latched high and `rail_5v` latched low, both strobes fall in the same cycle.
- R5: A strobe is high for exactly one cycle, and only while that channel's enable is high. A disabled channel produces no strobe, even while the other channel runs.
- R6: `track_mode` and `rail_5v` are captured only in cycles where both enables are low (or reset is high). A change while either channel is enabled affects neither the phase offset nor `force_pwm_ch2` until both channels have been disabled again.
- R7: After a cycle with both enables low, channel 1 strobes in the first cycle in which its enable is high, and channel 2 keeps its offset relative to the counter that started then. This holds even if channel 2 is enabled later.
- R8: `force_pwm_ch1` is high exactly while `ss_done_ch1` is low.
- R9: `force_pwm_ch2` is high while `ss_done_ch2` is low, and is also high whenever the latched `track_mode` is high.
- R10: While `rst` is high, no strobe is produced. In the first cycle after reset is released with channel 1 enabled, channel 1 strobes, and channel 2 follows at the offset given by the levels present during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_ch1 | input | 1 | Channel 1 enable |
| en_ch2 | input | 1 | Channel 2 enable |
| track_mode | input | 1 | 1 = channel 2 tracks channel 1 (memory supply mode) |
| rail_5v | input | 1 | 1 = power input is a regulated 5 V rail, 0 = battery-level input |
| ss_done_ch1 | input | 1 | Channel 1 soft-start has reached its completion level |
| ss_done_ch2 | input | 1 | Channel 2 soft-start has reached its completion level |
| cyc_start_ch1 | output | 1 | One-cycle strobe at the start of channel 1's period |
| cyc_start_ch2 | output | 1 | One-cycle strobe at the start of channel 2's period |
| force_pwm_ch1 | output | 1 | Channel 1 must stay in PWM operation |
| force_pwm_ch2 | output | 1 | Channel 2 must stay in PWM operation |

## Verification
The hardest case to reach from the ports is a change of the configuration levels while the channels are switching. It has to be shown that the change is ignored and is picked up only after a full disable. The stimulus starts both channels in the half-period mode and flips both levels in mid-period. It then measures the strobe spacing over two further periods and checks that `force_pwm_ch2` has stayed low. After that it drops both enables and restarts to see the quarter offset appear. A second hard case is enabling channel 2 long after channel 1. There the offset must come from the counter alignment set at the last idle cycle and not from the enable edge.

// File: rtl/pwm_phase_pkg.sv
`timescale 1ns/1ps
package pwm_phase_pkg;

    // Phase relationship of channel 2 relative to channel 1
    typedef enum logic [1:0] {
        PH_OPPOSED = 2'd0,   // half a period later
        PH_QUARTER = 2'd1,   // a quarter period later
        PH_ALIGNED = 2'd2    // same cycle
    } phase_e;

    // Latched configuration
    typedef struct packed {
        phase_e sel;
        logic   tracking;
    } mode_t;

    localparam int NCH = 2;

    function automatic phase_e decode_phase(input logic tracking, input logic rail5);
        if (!tracking)  return PH_OPPOSED;
        else if (rail5) return PH_QUARTER;
        else            return PH_ALIGNED;
    endfunction

    function automatic int unsigned phase_delay(input phase_e sel, input int unsigned period);
        case (sel)
            PH_OPPOSED: return period / 2;
            PH_QUARTER: return period / 4;
            default:    return 0;
        endcase
    endfunction

endpackage

// File: rtl/phase_select.sv
`timescale 1ns/1ps
module phase_select
    import pwm_phase_pkg::*;
#(
    parameter int unsigned PERIOD = 166,
    parameter int unsigned CW     = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          idle,
    input  logic          tracking_in,
    input  logic          rail5_in,
    output mode_t         mode_q,
    output logic [CW-1:0] preload_lag
);

    mode_t live;

    always_comb begin
        live.sel      = decode_phase(tracking_in, rail5_in);
        live.tracking = tracking_in;
        // Start value of the lagging counter so that it reaches zero
        // exactly phase_delay cycles after the leading counter does
        preload_lag   = CW'((PERIOD - phase_delay(live.sel, PERIOD)) % PERIOD);
    end

    always_ff @(posedge clk) begin
        if (rst || idle)
            mode_q <= live;
    end

    // R6: configuration is frozen while any channel runs
    a_r6_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        !idle |=> $stable(mode_q));

endmodule

// File: rtl/chan_timer.sv
`timescale 1ns/1ps
module chan_timer #(
    parameter int unsigned PERIOD = 166,
    parameter int unsigned CW     = 8
) (
    input  logic          clk,
    input  logic          load,
    input  logic [CW-1:0] preload,
    input  logic          enable,
    output logic          strobe,
    output logic [CW-1:0] count
);

    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (load)
            cnt <= preload;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign count  = cnt;
    assign strobe = enable && !load && (cnt == '0);

    // R5: a strobe never lasts two cycles
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (load)
        strobe |=> !strobe);

endmodule

// File: rtl/fpwm_ctl.sv
`timescale 1ns/1ps
module fpwm_ctl
    import pwm_phase_pkg::*;
(
    input  logic [NCH-1:0] ss_done,
    input  logic           tracking_q,
    output logic [NCH-1:0] force_pwm
);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        if (i == 1) begin : g_lag
            // The tracking channel may never drop into hysteretic operation
            assign force_pwm[i] = !ss_done[i] || tracking_q;
        end else begin : g_lead
            assign force_pwm[i] = !ss_done[i];
        end
    end

endmodule

// File: rtl/pwm_phase_clkgen.sv
`timescale 1ns/1ps
module pwm_phase_clkgen
    import pwm_phase_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int unsigned SW_HZ  = 300_000
) (
    input  logic clk,
    input  logic rst,
    input  logic en_ch1,
    input  logic en_ch2,
    input  logic track_mode,
    input  logic rail_5v,
    input  logic ss_done_ch1,
    input  logic ss_done_ch2,
    output logic cyc_start_ch1,
    output logic cyc_start_ch2,
    output logic force_pwm_ch1,
    output logic force_pwm_ch2
);

    localparam int unsigned PERIOD = CLK_HZ / SW_HZ;
    localparam int unsigned CW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic           idle;
    logic           load;
    mode_t          mode_q;
    logic [CW-1:0]  preload_lag;
    logic [NCH-1:0] en_v;
    logic [NCH-1:0] strobe_v;
    logic [CW-1:0]  preload_v [NCH];
    logic [CW-1:0]  count_v   [NCH];
    logic [NCH-1:0] force_v;

    assign idle = !en_ch1 && !en_ch2;
    assign load = rst || idle;

    assign en_v         = {en_ch2, en_ch1};
    assign preload_v[0] = '0;
    assign preload_v[1] = preload_lag;

    phase_select #(.PERIOD(PERIOD), .CW(CW)) u_sel (
        .clk         (clk),
        .rst         (rst),
        .idle        (idle),
        .tracking_in (track_mode),
        .rail5_in    (rail_5v),
        .mode_q      (mode_q),
        .preload_lag (preload_lag)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_tmr
        chan_timer #(.PERIOD(PERIOD), .CW(CW)) u_tmr (
            .clk     (clk),
            .load    (load),
            .preload (preload_v[i]),
            .enable  (en_v[i]),
            .strobe  (strobe_v[i]),
            .count   (count_v[i])
        );
    end

    fpwm_ctl u_fpwm (
        .ss_done    ({ss_done_ch2, ss_done_ch1}),
        .tracking_q (mode_q.tracking),
        .force_pwm  (force_v)
    );

    assign cyc_start_ch1 = strobe_v[0];
    assign cyc_start_ch2 = strobe_v[1];
    assign force_pwm_ch1 = force_v[0];
    assign force_pwm_ch2 = force_v[1];

    // R2: channel 2 starts half a period behind the leading counter
    a_r2_opposed: assert property (@(posedge clk) disable iff (rst)
        (cyc_start_ch2 && mode_q.sel == PH_OPPOSED) |-> count_v[0] == CW'(PERIOD / 2));

    // R3: quarter-period lag
    a_r3_quarter: assert property (@(posedge clk) disable iff (rst)
        (cyc_start_ch2 && mode_q.sel == PH_QUARTER) |-> count_v[0] == CW'(PERIOD / 4));

    // R4: in-phase strobes coincide when both channels run
    a_r4_aligned: assert property (@(posedge clk) disable iff (rst)
        (cyc_start_ch2 && en_ch1 && mode_q.sel == PH_ALIGNED) |-> cyc_start_ch1);

    // R9: tracking operation always forces channel 2 into PWM
    a_r9_track_forced: assert property (@(posedge clk) disable iff (rst)
        mode_q.tracking |-> force_pwm_ch2);

    // R10: reset silences both strobes
    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |-> !(cyc_start_ch1 || cyc_start_ch2));

endmodule

// File: tb/pwm_phase_clkgen_tb.sv
`timescale 1ns/1ps
module pwm_phase_clkgen_tb;

    localparam int P    = 50_000_000 / 300_000;  // 166
    localparam int HALF = P / 2;                 // 83
    localparam int QTR  = P / 4;                 // 41

    // {track_mode, rail_5v, expected lag, expected force_pwm_ch2 with ss done}
    localparam int VEC [4][4] = '{
        '{0, 0, HALF, 0},
        '{0, 1, HALF, 0},
        '{1, 1, QTR,  1},
        '{1, 0, 0,    1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_ch1 = 1'b0, en_ch2 = 1'b0;
    logic track_mode = 1'b0, rail_5v = 1'b0;
    logic ss_done_ch1 = 1'b1, ss_done_ch2 = 1'b1;
    logic cyc_start_ch1, cyc_start_ch2, force_pwm_ch1, force_pwm_ch2;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pwm_phase_clkgen u_dut (
        .clk(clk), .rst(rst), .en_ch1(en_ch1), .en_ch2(en_ch2),
        .track_mode(track_mode), .rail_5v(rail_5v),
        .ss_done_ch1(ss_done_ch1), .ss_done_ch2(ss_done_ch2),
        .cyc_start_ch1(cyc_start_ch1), .cyc_start_ch2(cyc_start_ch2),
        .force_pwm_ch1(force_pwm_ch1), .force_pwm_ch2(force_pwm_ch2)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Samples n cycles starting at the current negedge (+1 ns).
    // Records the first two strobe indices of each channel and any
    // strobe that stayed high for two samples in a row.
    task automatic measure(input int n, output int a0, output int a1,
                           output int b0, output int b1, output int wide);
        logic pa, pb;
        a0 = -1; a1 = -1; b0 = -1; b1 = -1; wide = 0;
        pa = 1'b0; pb = 1'b0;
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            #1;
            if (cyc_start_ch1) begin
                if (a0 < 0) a0 = k; else if (a1 < 0) a1 = k;
                if (pa) wide++;
            end
            if (cyc_start_ch2) begin
                if (b0 < 0) b0 = k; else if (b1 < 0) b1 = k;
                if (pb) wide++;
            end
            pa = cyc_start_ch1;
            pb = cyc_start_ch2;
        end
    endtask

    task automatic go_idle(input logic trk, input logic r5);
        @(negedge clk);
        en_ch1 = 1'b0; en_ch2 = 1'b0;
        track_mode = trk; rail_5v = r5;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int a0, a1, b0, b1, wide;
        string rq;

        // ---- reset state (R10) ----
        en_ch1 = 1'b1; en_ch2 = 1'b1; track_mode = 1'b1; rail_5v = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            check("R10 strobes quiet in reset", int'(cyc_start_ch1 | cyc_start_ch2), 0);
        end
        @(negedge clk);
        rst = 1'b0;
        measure(2 * P, a0, a1, b0, b1, wide);
        check("R10 ch1 first strobe after reset", a0, 0);
        check("R10 ch2 lag after reset", b0, QTR);

        // ---- table of modes (R1..R5, R7, R9) ----
        for (int v = 0; v < 4; v++) begin
            go_idle(VEC[v][0][0], VEC[v][1][0]);
            en_ch1 = 1'b1; en_ch2 = 1'b1;
            measure(2 * P, a0, a1, b0, b1, wide);
            rq = (VEC[v][2] == HALF) ? "R2" : (VEC[v][2] == QTR) ? "R3" : "R4";
            check("R7 ch1 strobes on enable", a0, 0);
            check("R1 ch1 period", a1 - a0, P);
            check({rq, " ch2 lag"}, b0, VEC[v][2]);
            check("R1 ch2 period", b1 - b0, P);
            check("R5 single-cycle strobes", wide, 0);
            check("R9 force_pwm_ch2 with ss done", int'(force_pwm_ch2), VEC[v][3]);
            check("R8 force_pwm_ch1 with ss done", int'(force_pwm_ch1), 0);
        end

        // ---- mode change while running is ignored (R6) ----
        go_idle(1'b0, 1'b0);
        en_ch1 = 1'b1; en_ch2 = 1'b1;
        repeat (20) @(negedge clk);
        track_mode = 1'b1; rail_5v = 1'b1;
        measure(2 * P, a0, a1, b0, b1, wide);
        check("R6 lag unchanged mid-run", (b0 - a0 + P) % P, HALF);
        check("R6 force_pwm_ch2 unchanged mid-run", int'(force_pwm_ch2), 0);
        @(negedge clk);
        en_ch1 = 1'b0; en_ch2 = 1'b0;
        repeat (3) @(negedge clk);
        en_ch1 = 1'b1; en_ch2 = 1'b1;
        measure(2 * P, a0, a1, b0, b1, wide);
        check("R6 new lag after idle", b0, QTR);
        check("R6 force_pwm_ch2 after idle", int'(force_pwm_ch2), 1);

        // ---- one channel only, then late enable (R5, R7) ----
        go_idle(1'b1, 1'b1);
        en_ch1 = 1'b1;
        measure(2 * P, a0, a1, b0, b1, wide);
        check("R5 disabled ch2 silent", b0, -1);
        check("R1 ch1 alone period", a1 - a0, P);
        @(negedge clk);
        en_ch2 = 1'b1;
        measure(2 * P, a0, a1, b0, b1, wide);
        check("R7 late ch2 keeps R3 lag", (b0 - a0 + P) % P, QTR);
        go_idle(1'b0, 1'b0);
        en_ch2 = 1'b1;
        measure(2 * P, a0, a1, b0, b1, wide);
        check("R5 disabled ch1 silent", a0, -1);
        check("R7 ch2 alone first strobe at R2 lag", b0, HALF);

        // ---- forced PWM flags (R8, R9) ----
        go_idle(1'b0, 1'b0);
        ss_done_ch1 = 1'b0; ss_done_ch2 = 1'b1; #1;
        check("R8 force_pwm_ch1 during soft-start", int'(force_pwm_ch1), 1);
        check("R9 force_pwm_ch2 released", int'(force_pwm_ch2), 0);
        @(negedge clk);
        ss_done_ch1 = 1'b1; ss_done_ch2 = 1'b0; #1;
        check("R8 force_pwm_ch1 released", int'(force_pwm_ch1), 0);
        check("R9 force_pwm_ch2 during soft-start", int'(force_pwm_ch2), 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule